// File: doc/BRIEF.md
# Overcurrent Alert Latch Controller

This block decides when a supply rail's overcurrent alert must be raised. It watches two sources. The first is a digital check: each new 12-bit current result from the converter is compared against a programmable 8-bit limit. The second is an analog comparator flag, which arrives as a synchronous level. Alert causes are captured in sticky status bits. The block drives an enable for an external open-drain pull-down, so that several such monitors can share one active-low alert wire.

Software configures the block through a small register write port with three registers:

- an enable register, which selects the digital trip mode, gates analog capture, allows software override and issues a one-shot clear;
- the 8-bit limit;
- a control register, which holds the software-off bit.

The digital trip can fire on one over-limit sample, or only after a run of four consecutive over-limit samples. A clear command drops the latched causes. Any cause that is still active sets its bit again immediately.

Top module: `ocp_alert_latch`

## Requirements
- R1: After reset the limit is 0xFF, only analog capture (enable bit 2) is on, all status bits are 0 and `alert_pull` is 0. A code of 0xFFF therefore does not trip.
- R2: A sample is over the limit when `cur_code[11:4]` is strictly greater than the limit. Status bit 0 shows the over-limit result of the most recent valid sample, one cycle after it, and holds between samples.
- R3: With enable bit 0 set, a single over-limit sample sets the latched digital alert (status bit 1) in the same cycle that status bit 0 updates. A sample equal to the limit does not.
- R4: With enable bit 1 set, status bit 1 sets only on the fourth consecutive over-limit sample. A sample at or below the limit restarts the run. The run count saturates at four, so further over-limit samples keep tripping.
- R5: Status bit 2 is the analog flag delayed by one cycle. With enable bit 2 set, a high flag sets the latched analog alert (status bit 3), which holds after the flag falls. With enable bit 2 clear, it never latches.
- R6: Writing the enable register with bit 4 set clears status bits 1, 3 and 5 one cycle after the write. The clear acts once. A cause that is still present keeps its bit set.
- R7: Control bit 0 appears as status bit 4 right after its write. Only while enable bit 3 is also set does it force `alert_pull` low, and in that case it sets the latched off alert (status bit 5) one cycle later.
- R8: `alert_pull` is 1 whenever status bit 1 or status bit 3 is set and the software override of R7 is not in force. Otherwise it is 0.
- R9: `reg_sel` selects 0 for enable, 1 for limit and 2 for control. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 enable, 1 limit, 2 control) |
| reg_wdata | input | 8 | Register write data |
| cur_valid | input | 1 | New current result strobe |
| cur_code | input | 12 | Current conversion result |
| ana_oc | input | 1 | Synchronous analog overcurrent flag |
| status | output | 6 | Live and latched alert status |
| alert_pull | output | 1 | Enable for the open-drain pull-down of the alert line |

## Verification
Several properties are checked on every cycle:

- a latched cause bit only rises after its source was present;
- latched bits only fall after a clear pulse;
- status bit 0 only moves after a valid sample;
- the pull-down is never on without a latched cause;
- the pull-down is never on while the override is in force.

The bench scenarios cover what needs history or exact values. These are the strict-versus-equal comparison, the four-sample run with its restart and saturation, re-latching on a clear while the cause is held, the delayed setting of the off alert, and the unmapped register select.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int ST_W      = 6;
  localparam int ST_OVER   = 0;
  localparam int ST_DLAT   = 1;
  localparam int ST_ALIVE  = 2;
  localparam int ST_ALAT   = 3;
  localparam int ST_OFF    = 4;
  localparam int ST_OLAT   = 5;

  localparam int EN_SINGLE = 0;
  localparam int EN_RUN    = 1;
  localparam int EN_ANA    = 2;
  localparam int EN_OFFOK  = 3;
  localparam int EN_CLR    = 4;
  localparam int EN_W      = 4;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_THR = 2'd1,
    SEL_CTL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ocp_regs.sv
module ocp_regs
  import ocp_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [EN_W-1:0]  en_bits,
  output logic             clr_pulse,
  output logic [REG_W-1:0] thr,
  output logic             soft_off
);
  logic [EN_W-1:0]  en_q, en_n;
  logic             clr_q, clr_n;
  logic [REG_W-1:0] thr_q, thr_n;
  logic             off_q, off_n;
  logic             unused_hi;

  assign unused_hi = ^wdata[REG_W-1:EN_CLR+1];

  always_comb begin
    en_n  = en_q;
    thr_n = thr_q;
    off_n = off_q;
    clr_n = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_EN: begin
          en_n  = wdata[EN_W-1:0];
          clr_n = wdata[EN_CLR];
        end
        SEL_THR: thr_n = wdata;
        SEL_CTL: off_n = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_W'(1 << EN_ANA);
      clr_q <= 1'b0;
      thr_q <= '1;
      off_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      clr_q <= clr_n;
      thr_q <= thr_n;
      off_q <= off_n;
    end
  end

  assign en_bits   = en_q;
  assign clr_pulse = clr_q;
  assign thr       = thr_q;
  assign soft_off  = off_q;
endmodule

// File: rtl/ocp_cur_check.sv
module ocp_cur_check #(
  parameter int CODE_W  = 12,
  parameter int THR_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_valid,
  input  logic [CODE_W-1:0] cur_code,
  input  logic [THR_W-1:0]  thr,
  input  logic              en_single,
  input  logic              en_run,
  output logic              over_q,
  output logic              trip
);
  localparam int SHIFT = CODE_W - THR_W;
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             over_n, over_now;
  logic             unused_lsb;

  assign unused_lsb = ^cur_code[SHIFT-1:0];
  assign over_now   = cur_code[CODE_W-1:SHIFT] > thr;

  always_comb begin
    cnt_n  = cnt_q;
    over_n = over_q;
    if (cur_valid) begin
      over_n = over_now;
      if (!over_now)            cnt_n = '0;
      else if (cnt_q != RUN_MAX) cnt_n = cnt_q + 1'b1;
    end
  end

  assign trip = cur_valid && over_now && (en_single || (en_run && cnt_n == RUN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      over_q <= over_n;
    end
  end
endmodule

// File: rtl/ocp_sticky.sv
module ocp_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_n;

  always_comb q_n = (q && !clr) || set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_n;
  end
endmodule

// File: rtl/ocp_alert_latch.sv
module ocp_alert_latch
  import ocp_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int REG_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              cur_valid,
  input  logic [CODE_W-1:0] cur_code,
  input  logic              ana_oc,
  output logic [ST_W-1:0]   status,
  output logic              alert_pull
);
  localparam int N_LAT = 3;

  logic [EN_W-1:0]  en_bits;
  logic             clr_pulse;
  logic [REG_W-1:0] thr;
  logic             soft_off;
  logic             over_q, dig_trip;
  logic             ana_q;
  logic             off_mask;
  logic [N_LAT-1:0] lat_set, lat_q;

  ocp_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .en_bits(en_bits), .clr_pulse(clr_pulse), .thr(thr), .soft_off(soft_off)
  );

  ocp_cur_check #(.CODE_W(CODE_W), .THR_W(REG_W), .RUN_LEN(RUN_LEN)) u_cur (
    .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .cur_code(cur_code),
    .thr(thr), .en_single(en_bits[EN_SINGLE]), .en_run(en_bits[EN_RUN]),
    .over_q(over_q), .trip(dig_trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ana_q <= 1'b0;
    else        ana_q <= ana_oc;
  end

  assign off_mask = soft_off && en_bits[EN_OFFOK];

  assign lat_set[0] = dig_trip;
  assign lat_set[1] = ana_oc && en_bits[EN_ANA];
  assign lat_set[2] = off_mask;

  genvar g;
  generate
    for (g = 0; g < N_LAT; g++) begin : g_lat
      ocp_sticky u_lat (
        .clk(clk), .rst_n(rst_n), .set(lat_set[g]), .clr(clr_pulse), .q(lat_q[g])
      );
    end
  endgenerate

  always_comb begin
    status           = '0;
    status[ST_OVER]  = over_q;
    status[ST_DLAT]  = lat_q[0];
    status[ST_ALIVE] = ana_q;
    status[ST_ALAT]  = lat_q[1];
    status[ST_OFF]   = soft_off;
    status[ST_OLAT]  = lat_q[2];
  end

  assign alert_pull = (lat_q[0] || lat_q[1]) && !off_mask;
endmodule

// File: rtl/ocp_alert_latch_chk.sv
module ocp_alert_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cur_valid,
  input logic       ana_oc,
  input logic [5:0] status,
  input logic       alert_pull,
  input logic       clr,
  input logic       off_mask
);
  AST_BIT0_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[0]) |-> $past(cur_valid)); // R2
  AST_DLAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cur_valid)); // R3
  AST_ALAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(ana_oc)); // R5
  AST_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[1]) || $fell(status[3]) || $fell(status[5])) |-> $past(clr)); // R6
  AST_OFF_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    off_mask |-> !alert_pull); // R7
  AST_ALERT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pull |-> (status[1] || status[3])); // R8
endmodule

bind ocp_alert_latch ocp_alert_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .ana_oc(ana_oc),
  .status(status), .alert_pull(alert_pull), .clr(clr_pulse), .off_mask(off_mask)
);

// File: tb/tb_ocp_alert_latch.sv
`timescale 1ns/1ps
module tb_ocp_alert_latch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic        cur_valid;
  logic [11:0] cur_code;
  logic        ana_oc;
  logic [5:0]  status;
  logic        alert_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ocp_alert_latch dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cur_valid(cur_valid), .cur_code(cur_code),
    .ana_oc(ana_oc), .status(status), .alert_pull(alert_pull)
  );

  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {12'h800, 1'b0}, {12'h80F, 1'b0}, {12'h810, 1'b1},
    {12'hFFF, 1'b1}, {12'h000, 1'b0}, {12'h7FF, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic feed(input logic [11:0] c);
    cur_valid = 1'b1; cur_code = c;
    step();
    cur_valid = 1'b0;
  endtask

  task automatic st(input string req, input logic [5:0] es, input logic ea);
    chk(req, {2'b00, status}, {2'b00, es});
    chk(req, {7'd0, alert_pull}, {7'd0, ea});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    cur_valid = 1'b0; cur_code = 12'h000; ana_oc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    st("R1 reset", 6'h00, 1'b0);

    // R1 default analog capture, R5 live and latched
    ana_oc = 1'b1; step(); ana_oc = 1'b0;
    st("R5 analog latch", 6'h0C, 1'b1);
    step();
    st("R5 analog hold", 6'h08, 1'b1);

    // R6 clear, re-latch, self-clearing
    wr(2'd0, 8'h14); step();
    st("R6 clear", 6'h00, 1'b0);
    ana_oc = 1'b1; step();
    wr(2'd0, 8'h14); step();
    st("R6 relatch", 6'h0C, 1'b1);
    ana_oc = 1'b0; step();
    wr(2'd0, 8'h14); step();
    st("R6 cause gone", 6'h00, 1'b0);
    ana_oc = 1'b1; step(); ana_oc = 1'b0; step(); step();
    st("R6 clear one-shot", 6'h08, 1'b1);
    wr(2'd0, 8'h14); step();

    // R5 capture disabled
    wr(2'd0, 8'h00);
    ana_oc = 1'b1; step();
    st("R5 disabled", 6'h04, 1'b0);
    ana_oc = 1'b0; step();

    // R1 default limit 0xFF, R3 single trip
    wr(2'd0, 8'h01);
    feed(12'hFFF);
    st("R1 default limit", 6'h00, 1'b0);
    wr(2'd1, 8'h80);
    feed(12'h810);
    st("R3 single trip", 6'h03, 1'b1);
    wr(2'd0, 8'h11); step();
    st("R6 digital clear", 6'h01, 1'b0);

    // R2 comparison table
    wr(2'd0, 8'h00);
    for (int i = 0; i < NV; i++) begin
      feed(VEC[i][12:1]);
      st("R2 compare", {5'd0, VEC[i][0]}, 1'b0);
    end
    step();
    st("R2 hold between samples", 6'h00, 1'b0);
    wr(2'd0, 8'h01);
    feed(12'h80F);
    st("R3 equal no trip", 6'h00, 1'b0);

    // R4 consecutive run
    wr(2'd0, 8'h02);
    for (int i = 0; i < 3; i++) begin
      feed(12'h900);
      st("R4 run below four", 6'h01, 1'b0);
    end
    feed(12'h100);
    st("R4 run restart", 6'h00, 1'b0);
    for (int i = 0; i < 3; i++) feed(12'h900);
    st("R4 three again", 6'h01, 1'b0);
    feed(12'h900);
    st("R4 fourth trips", 6'h03, 1'b1);
    wr(2'd0, 8'h12); step();
    st("R6 run clear", 6'h01, 1'b0);
    feed(12'h900);
    st("R4 saturated retrip", 6'h03, 1'b1);

    // R7 software off
    wr(2'd2, 8'h01);
    st("R7 off without enable", 6'h13, 1'b1);
    step();
    st("R7 no off latch", 6'h13, 1'b1);
    wr(2'd0, 8'h0A);
    chk("R7 override immediate", {7'd0, alert_pull}, 8'h00);
    step();
    st("R7 off latch", 6'h33, 1'b0);
    wr(2'd2, 8'h00);
    st("R8 alert returns", 6'h23, 1'b1);
    wr(2'd0, 8'h1A); step();
    st("R6 clear all", 6'h01, 1'b0);

    // R9 unmapped select
    wr(2'd3, 8'hFF); step();
    st("R9 unmapped write", 6'h01, 1'b0);
    feed(12'h100);
    feed(12'h810);
    st("R9 limit kept", 6'h01, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule